// File: doc/BRIEF.md
# Burst Acquisition Trigger Controller

This block sits between a free-running ADC sample stream and a host-facing streaming output. It passes on only triggered bursts. While armed, each incoming sample is written into a circular history buffer and nothing reaches the output. A trigger starts a burst. The trigger is either a rising edge on an asynchronous external pin or a one-cycle software strobe. A burst is a train of records, and the output marks the final sample of each record.

A small descriptor table, written by the host, gives the shape of the burst. Each entry holds a record length and a start-to-start spacing. Record k of a burst uses entry k, so lengths and spacings can differ within one burst. A global count sets how many records one trigger produces. A global pretrigger depth sets how many samples from before each record's start point open that record. The controller takes one sample per clock. The external trigger is resolved only to the sample clock, so its placement is uncertain by one sample period.

Top module: `burst_capture`

## Requirements
- R1: Out of reset `out_vld`, `busy` and `pre_clamped` are 0. While no burst is running, `out_vld` stays 0 whatever the sample input does.
- R2: A one-cycle `sw_trig` pulse in the cycle that presents sample S starts a burst whose trigger point is the next sample, S+1.
- R3: A rising edge on `ext_trig` passes through a two-stage synchroniser and an edge detector. If the pin is first seen high at the edge that takes sample S, the trigger point is sample S+3.
- R4: Record k holds exactly `len[k]` samples, and they are consecutive input samples.
- R5: The start point of record k+1 lies `per[k]` samples after the start point of record k. A spacing equal to the length gives back-to-back records.
- R6: One trigger yields exactly `cfg_nrec` records, which use table entries 0 to `cfg_nrec`-1 in order.
- R7: Record k begins D samples before its start point, where D = min(`cfg_pre`, 2^HIST_AW, `len[k]`).
- R8: Descriptor entries are written at index `desc_idx` when `desc_we` is high. Each record takes its length and spacing from its own entry.
- R9: `out_last` is 1 on the final sample of every record and on no other sample.
- R10: `sw_trig` pulses and `ext_trig` edges that arrive while `busy` is 1 are ignored. They start no burst and add no samples.
- R11: If `cfg_pre` exceeds the buffer depth or the record length, the depth is clamped as in R7 and `pre_clamped` becomes 1. It then stays 1 until reset.
- R12: The configuration is rejected if `cfg_nrec` is 0, if `cfg_nrec` exceeds the table size, or if any used entry has a zero length or a spacing below its length. On rejection `cfg_err` is 1 and a trigger starts nothing. The table resets to all zeros, so `cfg_err` is 1 until it is programmed.
- R13: After the final sample of the final record, the controller is armed again and accepts the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | DATA_W | ADC sample, one per clock |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| sw_trig | input | 1 | Software trigger strobe, synchronous |
| cfg_nrec | input | DESC_AW+1 | Records per trigger |
| cfg_pre | input | 12 | Requested pretrigger depth |
| desc_we | input | 1 | Descriptor write enable |
| desc_idx | input | DESC_AW | Descriptor entry index |
| desc_len | input | 12 | Record length to write |
| desc_per | input | 12 | Start-to-start spacing to write |
| out_vld | output | 1 | Output sample valid |
| out_data | output | DATA_W | Output sample |
| out_last | output | 1 | Final sample of a record |
| busy | output | 1 | Burst in progress |
| cfg_err | output | 1 | Current configuration rejected |
| pre_clamped | output | 1 | Sticky pretrigger clamp flag |

## Verification
The bench drives a counting sample stream, so every output word shows which input sample it came from. A history read pointer that is off by one makes the first data word of a burst wrong. A wrong record position or a wrong record index shows up within one record, as a misplaced `out_last` or as a jump in the data. A sequencer that fails to return to armed, or that restarts on a trigger it should ignore, shows as missing or surplus valid words. The scoreboard queue catches either one at the first word.

// File: rtl/bt_pkg.sv
`timescale 1ns/1ps
package bt_pkg;

    localparam int BT_LEN_W = 12;

    typedef enum logic {ST_ARMED, ST_RUN} seq_st_t;

    typedef struct packed {
        logic [BT_LEN_W-1:0] len;
        logic [BT_LEN_W-1:0] per;
    } bt_desc_t;

    // Effective pretrigger depth: the request limited by buffer depth and record length
    function automatic logic [BT_LEN_W-1:0] bt_pre_limit(
        input logic [BT_LEN_W-1:0] req,
        input logic [BT_LEN_W-1:0] len,
        input logic [BT_LEN_W-1:0] depth
    );
        logic [BT_LEN_W-1:0] lim;
        lim = (len < depth) ? len : depth;
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/bt_trig_sync.sv
`timescale 1ns/1ps
module bt_trig_sync (
    input  logic clk,
    input  logic rst,
    input  logic ext_trig,
    input  logic sw_trig,
    output logic trig_req
);
    logic [2:0] sh;
    logic       ext_rise;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], ext_trig};
    end

    assign ext_rise = sh[1] & ~sh[2];
    assign trig_req = ext_rise | sw_trig;

    // R3
    ext_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_req && !sw_trig) |-> ($past(ext_trig, 2) && !$past(ext_trig, 3)));

endmodule

// File: rtl/bt_hist_buf.sv
`timescale 1ns/1ps
module bt_hist_buf #(
    parameter int DATA_W  = 16,
    parameter int HIST_AW = 4,
    localparam int DEPTH  = 1 << HIST_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [HIST_AW:0]  dly,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0]  mem [DEPTH];
    logic [HIST_AW-1:0] wp;
    logic [HIST_AW-1:0] rp;

    assign rp      = wp - dly[HIST_AW-1:0];
    assign rd_data = (dly == '0) ? wr_data : mem[rp];

    always_ff @(posedge clk) begin
        mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) wp <= '0;
        else     wp <= wp + 1'b1;
    end

    // R7
    dly_range_chk: assert property (@(posedge clk) disable iff (rst)
        dly <= (HIST_AW+1)'(DEPTH));

endmodule

// File: rtl/bt_desc_table.sv
`timescale 1ns/1ps
module bt_desc_table
    import bt_pkg::*;
#(
    parameter int DESC_AW = 2,
    localparam int DESC_N = 1 << DESC_AW,
    localparam int REC_W  = DESC_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [DESC_AW-1:0] widx,
    input  bt_desc_t           wdesc,
    input  logic [DESC_AW-1:0] ridx,
    output bt_desc_t           rdesc,
    input  logic [REC_W-1:0]   nrec,
    output logic               cfg_ok
);
    bt_desc_t tbl [DESC_N];

    for (genvar g = 0; g < DESC_N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= '0;
            else if (we && widx == DESC_AW'(g))
                tbl[g] <= wdesc;
        end
    end

    assign rdesc = tbl[ridx];

    always_comb begin
        cfg_ok = (nrec != '0) && (nrec <= REC_W'(DESC_N));
        for (int i = 0; i < DESC_N; i++) begin
            if (REC_W'(i) < nrec &&
                (tbl[i].len == '0 || tbl[i].per < tbl[i].len))
                cfg_ok = 1'b0;
        end
    end

endmodule

// File: rtl/bt_seq.sv
`timescale 1ns/1ps
module bt_seq
    import bt_pkg::*;
#(
    parameter int HIST_AW = 4,
    parameter int DESC_AW = 2,
    localparam int REC_W  = DESC_AW + 1,
    localparam int DEPTH  = 1 << HIST_AW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_req,
    input  logic                cfg_ok,
    input  logic [REC_W-1:0]    cfg_nrec,
    input  logic [BT_LEN_W-1:0] cfg_pre,
    input  bt_desc_t            rdesc,
    output logic [DESC_AW-1:0]  ridx,
    output logic                emit,
    output logic                emit_last,
    output logic [HIST_AW:0]    dly,
    output logic                busy,
    output logic                pre_clamped,
    output logic                cfg_err
);
    localparam logic [BT_LEN_W-1:0] DEPTH_L = BT_LEN_W'(DEPTH);

    seq_st_t              st;
    logic [DESC_AW-1:0]   rec_idx, last_idx;
    logic [BT_LEN_W-1:0]  pos, cur_len, cur_per, run_pre;
    logic [BT_LEN_W-1:0]  pre_sel, ld_dly;
    logic                 ld_clamp, start, finish, adv;

    assign busy    = (st == ST_RUN);
    assign start   = (st == ST_ARMED) && trig_req && cfg_ok;
    assign pre_sel = (st == ST_ARMED) ? cfg_pre : run_pre;
    assign ridx    = (st == ST_ARMED) ? '0 : rec_idx + 1'b1;

    always_comb begin
        ld_dly   = bt_pre_limit(pre_sel, rdesc.len, DEPTH_L);
        ld_clamp = pre_sel > ld_dly;
    end

    assign emit      = busy && (pos < cur_len);
    assign emit_last = emit && (pos == cur_len - 1'b1);
    assign finish    = busy && (rec_idx == last_idx) && (pos == cur_len - 1'b1);
    assign adv       = busy && !finish && (pos == cur_per - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_ARMED;
            rec_idx     <= '0;
            last_idx    <= '0;
            pos         <= '0;
            cur_len     <= '0;
            cur_per     <= '0;
            run_pre     <= '0;
            dly         <= '0;
            pre_clamped <= 1'b0;
            cfg_err     <= 1'b0;
        end else begin
            cfg_err <= !cfg_ok;
            if (start) begin
                st       <= ST_RUN;
                rec_idx  <= '0;
                last_idx <= DESC_AW'(cfg_nrec - 1'b1);
                pos      <= '0;
                cur_len  <= rdesc.len;
                cur_per  <= rdesc.per;
                run_pre  <= cfg_pre;
                dly      <= ld_dly[HIST_AW:0];
                if (ld_clamp) pre_clamped <= 1'b1;
            end else if (finish) begin
                st <= ST_ARMED;
            end else if (adv) begin
                rec_idx <= ridx;
                pos     <= '0;
                cur_len <= rdesc.len;
                cur_per <= rdesc.per;
                dly     <= ld_dly[HIST_AW:0];
                if (ld_clamp) pre_clamped <= 1'b1;
            end else if (busy) begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && trig_req && cfg_ok) |=> (busy && pos == '0 && rec_idx == '0));

    // R10
    retrig_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && trig_req && !finish && !adv) |=> (pos == $past(pos) + 1'b1));

    // R5
    period_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rec_idx != last_idx) |-> (cur_per >= cur_len));

    // R7
    pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (BT_LEN_W'(dly) <= cur_len && BT_LEN_W'(dly) <= DEPTH_L));

    // R11
    clamp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        pre_clamped |=> pre_clamped);

    // R12
    cfg_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_ok) |=> !busy);

endmodule

// File: rtl/burst_capture.sv
`timescale 1ns/1ps
module burst_capture
    import bt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int HIST_AW = 4,
    parameter int DESC_AW = 2,
    localparam int REC_W  = DESC_AW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   smp_in,
    input  logic                ext_trig,
    input  logic                sw_trig,
    input  logic [REC_W-1:0]    cfg_nrec,
    input  logic [BT_LEN_W-1:0] cfg_pre,
    input  logic                desc_we,
    input  logic [DESC_AW-1:0]  desc_idx,
    input  logic [BT_LEN_W-1:0] desc_len,
    input  logic [BT_LEN_W-1:0] desc_per,
    output logic                out_vld,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_last,
    output logic                busy,
    output logic                cfg_err,
    output logic                pre_clamped
);
    logic               trig_req, cfg_ok, emit, emit_last;
    logic [DESC_AW-1:0] ridx;
    logic [HIST_AW:0]   dly;
    logic [DATA_W-1:0]  hist_q;
    bt_desc_t           wdesc, rdesc;

    assign wdesc.len = desc_len;
    assign wdesc.per = desc_per;

    bt_trig_sync u_trig (
        .clk      (clk),
        .rst      (rst),
        .ext_trig (ext_trig),
        .sw_trig  (sw_trig),
        .trig_req (trig_req)
    );

    bt_desc_table #(.DESC_AW(DESC_AW)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .we     (desc_we),
        .widx   (desc_idx),
        .wdesc  (wdesc),
        .ridx   (ridx),
        .rdesc  (rdesc),
        .nrec   (cfg_nrec),
        .cfg_ok (cfg_ok)
    );

    bt_seq #(.HIST_AW(HIST_AW), .DESC_AW(DESC_AW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig_req    (trig_req),
        .cfg_ok      (cfg_ok),
        .cfg_nrec    (cfg_nrec),
        .cfg_pre     (cfg_pre),
        .rdesc       (rdesc),
        .ridx        (ridx),
        .emit        (emit),
        .emit_last   (emit_last),
        .dly         (dly),
        .busy        (busy),
        .pre_clamped (pre_clamped),
        .cfg_err     (cfg_err)
    );

    bt_hist_buf #(.DATA_W(DATA_W), .HIST_AW(HIST_AW)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_data (smp_in),
        .dly     (dly),
        .rd_data (hist_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld  <= emit;
            out_last <= emit_last;
            out_data <= hist_q;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !out_vld);

    // R9
    last_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_vld);

endmodule

// File: tb/burst_capture_tb_top.sv
`timescale 1ns/1ps
module burst_capture_tb_top;
    localparam int DW = 16;
    localparam int HAW = 4;
    localparam int DAW = 2;
    localparam int DEPTH = 1 << HAW;
    localparam int LW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cyc = '0;
    logic ext_trig = 1'b0, sw_trig = 1'b0;
    logic [DAW:0] cfg_nrec = '0;
    logic [LW-1:0] cfg_pre = '0;
    logic desc_we = 1'b0;
    logic [DAW-1:0] desc_idx = '0;
    logic [LW-1:0] desc_len = '0, desc_per = '0;
    logic out_vld, out_last, busy, cfg_err, pre_clamped;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int len_m [4];
    int per_m [4];
    int nrec_m = 0;
    int pre_m = 0;

    logic [15:0] exp_d [$];
    bit          exp_l [$];
    string       exp_t [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 16'd1;

    burst_capture #(.DATA_W(DW), .HIST_AW(HAW), .DESC_AW(DAW)) dut_i (
        .clk(clk), .rst(rst), .smp_in(cyc), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .cfg_nrec(cfg_nrec), .cfg_pre(cfg_pre), .desc_we(desc_we), .desc_idx(desc_idx),
        .desc_len(desc_len), .desc_per(desc_per), .out_vld(out_vld), .out_data(out_data),
        .out_last(out_last), .busy(busy), .cfg_err(cfg_err), .pre_clamped(pre_clamped)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic prog(input int idx, input int len, input int per);
        @(negedge clk);
        desc_we = 1'b1; desc_idx = DAW'(idx); desc_len = LW'(len); desc_per = LW'(per);
        len_m[idx] = len; per_m[idx] = per;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic set_cfg(input int nrec, input int pre);
        @(negedge clk);
        cfg_nrec = (DAW+1)'(nrec); cfg_pre = LW'(pre);
        nrec_m = nrec; pre_m = pre;
    endtask

    // Driver: expected words of one burst from the trigger point
    task automatic push_burst(input logic [15:0] tp, input string tag);
        logic [15:0] st;
        int d;
        st = tp;
        for (int k = 0; k < nrec_m; k++) begin
            d = pre_m;
            if (d > DEPTH) d = DEPTH;
            if (d > len_m[k]) d = len_m[k];
            for (int j = 0; j < len_m[k]; j++) begin
                exp_d.push_back(st - 16'(d) + 16'(j));
                exp_l.push_back(j == len_m[k] - 1);
                exp_t.push_back(tag);
            end
            st = st + 16'(per_m[k]);
        end
    endtask

    task automatic fire_sw(output logic [15:0] tp);
        @(negedge clk);
        sw_trig = 1'b1;
        tp = cyc + 16'd1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic fire_ext(output logic [15:0] tp);
        @(negedge clk);
        ext_trig = 1'b1;
        tp = cyc + 16'd3;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_d.size() != 0 || busy) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops and compares each output word
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_vld) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R1", "out_vld with nothing pending", 1, 0);
                end else begin
                    logic [15:0] ed;
                    bit el;
                    string et;
                    ed = exp_d.pop_front();
                    el = exp_l.pop_front();
                    et = exp_t.pop_front();
                    chk(out_data == ed, et, "sample value", int'(out_data), int'(ed));
                    chk(out_last == el, "R9", "last flag", int'(out_last), int'(el));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R13", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [15:0] tp;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_vld == 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(pre_clamped == 1'b0, "R1", "pre_clamped after reset", int'(pre_clamped), 0);
        // R12 empty table is rejected
        chk(cfg_err == 1'b1, "R12", "cfg_err with empty table", int'(cfg_err), 1);

        // R8 descriptor programming
        prog(0, 4, 6);
        prog(1, 3, 3);
        prog(2, 5, 5);
        set_cfg(1, 2);
        repeat (24) @(negedge clk);
        chk(cfg_err == 1'b0, "R12", "cfg_err with valid table", int'(cfg_err), 0);
        chk(out_vld == 1'b0, "R1", "no output before trigger", int'(out_vld), 0);

        // R2 R4 R7 single record from software trigger
        fire_sw(tp);
        push_burst(tp, "R2");
        drain();

        // R5 R6 R8 three records, back to back on entry 1; R10 retriggers ignored
        set_cfg(3, 3);
        fire_sw(tp);
        push_burst(tp, "R5");
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy during burst", int'(busy), 1);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        drain();
        chk(exp_d.size() == 0, "R10", "pending after retrigger burst", exp_d.size(), 0);

        // R3 R13 external trigger, re-armed, no pretrigger
        set_cfg(2, 0);
        fire_ext(tp);
        push_burst(tp, "R3");
        drain();
        chk(pre_clamped == 1'b0, "R11", "pre_clamped before clamp", int'(pre_clamped), 0);

        // R11 clamp by buffer depth
        prog(0, 20, 20);
        set_cfg(1, 20);
        fire_sw(tp);
        push_burst(tp, "R11");
        drain();
        chk(pre_clamped == 1'b1, "R11", "pre_clamped after depth clamp", int'(pre_clamped), 1);

        // R11 clamp by record length, R7
        prog(0, 4, 6);
        set_cfg(1, 10);
        fire_sw(tp);
        push_burst(tp, "R7");
        drain();
        chk(pre_clamped == 1'b1, "R11", "pre_clamped stays set", int'(pre_clamped), 1);

        // R12 spacing below length rejected
        prog(0, 4, 2);
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, "R12", "cfg_err short spacing", int'(cfg_err), 1);
        fire_sw(tp);
        repeat (12) @(negedge clk);
        chk(busy == 1'b0, "R12", "busy after rejected trigger", int'(busy), 0);

        // R12 zero record count rejected
        prog(0, 4, 6);
        set_cfg(0, 1);
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, "R12", "cfg_err zero records", int'(cfg_err), 1);
        fire_sw(tp);
        repeat (12) @(negedge clk);
        chk(busy == 1'b0, "R12", "busy after zero-record trigger", int'(busy), 0);

        // R13 accepts a trigger again once valid
        set_cfg(2, 1);
        fire_sw(tp);
        push_burst(tp, "R13");
        drain();
        chk(exp_d.size() == 0, "R13", "pending at end", exp_d.size(), 0);
        report();
    end

endmodule